// File: doc/BRIEF.md
# Frame Statistics Counter Bank

This block holds eight free-running statistics counters for a network MAC, four per direction. Frame-status logic on the send and receive sides supplies one-cycle event pulses. Each pulse advances the matching counter. The good-octet counter is the exception: on its pulse it adds the byte count of the frame. Software reaches the counters, a control register, two interrupt status registers and two mask registers through a plain register port.

The register port is a control path. It has no valid/ready handshake and never back-pressures. A write takes effect at the clock edge where `reg_wr` is high. A read returns its data on `reg_rdata` one cycle after `reg_rd`, and no wait state is ever inserted.

Each counter reports a wide-range event whenever counting changes its most significant bit, which is either a crossing of half of full scale or a wrap to zero. Such an event latches a status bit. An interrupt line for each direction is raised while any unmasked status bit of that direction is set.

Top module: `mac_stat_bank`

## Requirements
- R1: After reset every counter, both status registers, both mask registers and the control register read as zero, and both interrupt outputs are low.
- R2: Each event pulse adds exactly one to its own counter, and simultaneous pulses on several lines each count. The send lines are `tx_ev` bit 0 (all frames), bit 1 (single collision) and bit 2 (multiple collisions). The receive lines are `rx_ev` bit 0 (all frames), bit 1 (CRC error), bit 2 (alignment error) and bit 3 (good unicast).
- R3: A pulse on `tx_ev` bit 3 adds the value of `tx_octets` to the good-octet counter.
- R4: The word address map is as follows. 0 is control, 1 is receive status, 2 is receive mask, 3 is send status and 4 is send mask. 8 to 11 are the send counters in `tx_ev` bit order, and 12 to 15 are the receive counters in `rx_ev` bit order. Read data appears on `reg_rdata` in the cycle after `reg_rd`.
- R5: Status bit i of a direction is set when counting changes the most significant bit of that direction's counter i, whether by crossing half scale or by wrapping to zero. No other cause sets a status bit.
- R6: A status bit stays set until its status register is read, and the read clears it. If a bit sets in the same cycle as the read, the newly set bit survives the read.
- R7: `tx_irq` and `rx_irq` are each high exactly when that direction has a status bit set whose mask bit (bits 3..0 of the mask register) is clear.
- R8: Writing control with bit 0 set zeroes all eight counters at that edge, and any event pulse in the same cycle is dropped. Bit 0 is not stored and always reads as zero.
- R9: While control bit 1 (freeze) is set, event pulses change no counter and set no status bit.
- R10: While control bit 2 (clear-on-read) is set, a counter read returns the current value and then leaves the counter at zero. If an event arrives in the cycle of that read, the counter is left holding only that event's amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_ev | input | 4 | Send-side event pulses |
| tx_octets | input | 16 | Byte count of the sent good frame |
| rx_ev | input | 4 | Receive-side event pulses |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the read strobe |
| tx_irq | output | 1 | Send-side interrupt |
| rx_irq | output | 1 | Receive-side interrupt |

## Verification
A counter with a wrong value can go unnoticed until software reads it. Its first visible sign, though, is the interrupt line: that line rises on the exact pulse that carries the counter over half scale, and a counter that is off rises a pulse early or late. The bench therefore steers the octet counter to one pulse short of half scale, and later one pulse short of a wrap, and checks the interrupt on the cycle before and on the cycle of the crossing. A stale status or mask bit shows up on the interrupt line in the same cycle, before any read is made.

// File: rtl/mac_stat_pkg.sv
package mac_stat_pkg;
  localparam int unsigned ADDR_W     = 4;
  localparam int unsigned EV_PER_DIR = 4;

  localparam logic [ADDR_W-1:0] A_CTRL    = 4'd0;
  localparam logic [ADDR_W-1:0] A_RX_STAT = 4'd1;
  localparam logic [ADDR_W-1:0] A_RX_MASK = 4'd2;
  localparam logic [ADDR_W-1:0] A_TX_STAT = 4'd3;
  localparam logic [ADDR_W-1:0] A_TX_MASK = 4'd4;

  localparam int unsigned CTL_CLR = 0;
  localparam int unsigned CTL_FRZ = 1;
  localparam int unsigned CTL_ROR = 2;

  localparam int unsigned OCT_IDX = 3;
endpackage

// File: rtl/stat_counter.sv
module stat_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             freeze,
  input  logic             rd_clr,
  input  logic             ev,
  input  logic [CNT_W-1:0] amt,
  output logic [CNT_W-1:0] count,
  output logic             msb_flip
);
  logic             take;
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] sum;

  always_comb begin
    take     = ev && !freeze && !clr_all;
    base     = rd_clr ? '0 : count;
    sum      = base + amt;
    msb_flip = take && (sum[CNT_W-1] != base[CNT_W-1]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (clr_all) count <= '0;
    else if (take)    count <= sum;
    else if (rd_clr)  count <= '0;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && !freeze && !clr_all && !rd_clr) |=> count == $past(count) + $past(amt)); // R2
  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !clr_all && !rd_clr) |=> $stable(count)); // R9
  AST_CNT_ROR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !ev && !clr_all) |=> count == '0); // R10
endmodule

// File: rtl/stat_dir.sv
module stat_dir #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned N     = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_all,
  input  logic                     freeze,
  input  logic [N-1:0]             ev,
  input  logic [N-1:0]             rd_clr,
  input  logic [N-1:0][CNT_W-1:0]  amt,
  input  logic                     st_rd,
  input  logic                     mask_wr,
  input  logic [N-1:0]             mask_wdata,
  output logic [N-1:0][CNT_W-1:0]  counts,
  output logic [N-1:0]             status,
  output logic [N-1:0]             mask,
  output logic                     irq
);
  logic [N-1:0] flip;

  for (genvar i = 0; i < N; i++) begin : g_cnt
    stat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_all  (clr_all),
      .freeze   (freeze),
      .rd_clr   (rd_clr[i]),
      .ev       (ev[i]),
      .amt      (amt[i]),
      .count    (counts[i]),
      .msb_flip (flip[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      mask   <= '0;
    end else begin
      status <= (st_rd ? '0 : status) | flip;
      if (mask_wr) mask <= mask_wdata;
    end
  end

  assign irq = |(status & ~mask);

  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !st_rd |=> (status & $past(status)) == $past(status)); // R6
  AST_STAT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (flip == '0) |=> (status & ~$past(status)) == '0); // R5
endmodule

// File: rtl/mac_stat_bank.sv
module mac_stat_bank
  import mac_stat_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned OCT_W = 16,
  parameter int unsigned REG_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        tx_ev,
  input  logic [OCT_W-1:0]  tx_octets,
  input  logic [3:0]        rx_ev,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              tx_irq,
  output logic              rx_irq
);
  localparam int unsigned N = EV_PER_DIR;

  logic                    freeze_q, ror_q;
  logic                    clr_all;
  logic [N-1:0]            tx_rdclr, rx_rdclr;
  logic [N-1:0][CNT_W-1:0] tx_amt, rx_amt, tx_cnt, rx_cnt;
  logic [N-1:0]            tx_stat, rx_stat, tx_mask, rx_mask;
  logic                    cnt_hit;
  logic [REG_W-1:0]        rd_mux;

  assign clr_all = reg_wr && (reg_addr == A_CTRL) && reg_wdata[CTL_CLR];
  assign cnt_hit = reg_rd && reg_addr[3] && ror_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      freeze_q <= 1'b0;
      ror_q    <= 1'b0;
    end else if (reg_wr && reg_addr == A_CTRL) begin
      freeze_q <= reg_wdata[CTL_FRZ];
      ror_q    <= reg_wdata[CTL_ROR];
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      tx_amt[i]   = (i == OCT_IDX) ? CNT_W'(tx_octets) : CNT_W'(1);
      rx_amt[i]   = CNT_W'(1);
      tx_rdclr[i] = cnt_hit && !reg_addr[2] && (reg_addr[1:0] == 2'(i));
      rx_rdclr[i] = cnt_hit &&  reg_addr[2] && (reg_addr[1:0] == 2'(i));
    end
  end

  stat_dir #(.CNT_W(CNT_W), .N(N)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_all    (clr_all),
    .freeze     (freeze_q),
    .ev         (tx_ev),
    .rd_clr     (tx_rdclr),
    .amt        (tx_amt),
    .st_rd      (reg_rd && reg_addr == A_TX_STAT),
    .mask_wr    (reg_wr && reg_addr == A_TX_MASK),
    .mask_wdata (reg_wdata[N-1:0]),
    .counts     (tx_cnt),
    .status     (tx_stat),
    .mask       (tx_mask),
    .irq        (tx_irq)
  );

  stat_dir #(.CNT_W(CNT_W), .N(N)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_all    (clr_all),
    .freeze     (freeze_q),
    .ev         (rx_ev),
    .rd_clr     (rx_rdclr),
    .amt        (rx_amt),
    .st_rd      (reg_rd && reg_addr == A_RX_STAT),
    .mask_wr    (reg_wr && reg_addr == A_RX_MASK),
    .mask_wdata (reg_wdata[N-1:0]),
    .counts     (rx_cnt),
    .status     (rx_stat),
    .mask       (rx_mask),
    .irq        (rx_irq)
  );

  always_comb begin
    rd_mux = '0;
    if (reg_addr[3]) begin
      rd_mux = reg_addr[2] ? REG_W'(rx_cnt[reg_addr[1:0]]) : REG_W'(tx_cnt[reg_addr[1:0]]);
    end else begin
      case (reg_addr)
        A_CTRL:    begin
          rd_mux[CTL_FRZ] = freeze_q;
          rd_mux[CTL_ROR] = ror_q;
        end
        A_RX_STAT: rd_mux = REG_W'(rx_stat);
        A_RX_MASK: rd_mux = REG_W'(rx_mask);
        A_TX_STAT: rd_mux = REG_W'(tx_stat);
        A_TX_MASK: rd_mux = REG_W'(tx_mask);
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  AST_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (tx_cnt == '0 && rx_cnt == '0)); // R8
  AST_IRQ_SILENT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mask == '1) |-> !tx_irq); // R7
endmodule

// File: tb/mac_stat_bank_tb_top.sv
module mac_stat_bank_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  tx_ev = '0;
  logic [15:0] tx_octets = '0;
  logic [3:0]  rx_ev = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_irq, rx_irq;

  int       n_total = 0;
  int       n_bad = 0;
  bit       done = 1'b0;
  bit       pend = 1'b0;
  sb_item_t sbq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_stat_bank dut_i (
    .clk(clk), .rst_n(rst_n), .tx_ev(tx_ev), .tx_octets(tx_octets), .rx_ev(rx_ev),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_total++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  always @(posedge clk) pend <= reg_rd;

  always @(negedge clk) begin
    if (pend) begin
      if (sbq.size() == 0) check(32'hDEAD, 32'h0, "monitor queue empty");
      else begin
        sb_item_t it;
        it = sbq.pop_front();
        check(reg_rdata, it.exp, it.tag);
      end
    end
  end

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    sbq.push_back('{e, t});
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] t, input logic [3:0] r, input logic [15:0] o);
    @(negedge clk);
    tx_ev = t; rx_ev = r; tx_octets = o;
    @(negedge clk);
    tx_ev = '0; rx_ev = '0;
  endtask

  task automatic oct_burst(input int n);
    @(negedge clk);
    tx_ev[3] = 1'b1; tx_octets = 16'hFFFF;
    repeat (n) @(negedge clk);
    tx_ev[3] = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_total++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check({30'd0, tx_irq, rx_irq}, 32'd0, "R1 irq low after reset");
    for (int a = 0; a < 16; a++) rd(4'(a), 32'd0, "R1 register zero after reset");

    // R2: single counts, simultaneous pulses
    pulse(4'b0111, 4'b1111, 16'd0);
    pulse(4'b0001, 4'b0000, 16'd0);
    rd(4'd8,  32'd2, "R2 tx all-frames");
    rd(4'd9,  32'd1, "R2 tx single collision");
    rd(4'd10, 32'd1, "R2 tx multiple collision");
    for (int a = 12; a < 16; a++) rd(4'(a), 32'd1, "R2 rx counter");

    // R3: octets
    pulse(4'b1000, 4'b0000, 16'd100);
    pulse(4'b1000, 4'b0000, 16'd28);
    rd(4'd11, 32'd128, "R3 good octets accumulate");

    // R9 freeze, R4 control readback
    wr(4'd0, 32'h2);
    rd(4'd0, 32'h2, "R4 control reads freeze bit");
    pulse(4'b1111, 4'b1111, 16'd5);
    rd(4'd12, 32'd1, "R9 rx frame frozen");
    rd(4'd11, 32'd128, "R9 octets frozen");
    check({30'd0, tx_irq, rx_irq}, 32'd0, "R9 no status while frozen");
    wr(4'd0, 32'h0);

    // R10 clear-on-read
    wr(4'd0, 32'h4);
    rd(4'd13, 32'd1, "R10 first read returns value");
    rd(4'd13, 32'd0, "R10 second read after clear");
    @(negedge clk);
    reg_addr = 4'd12; reg_rd = 1'b1; rx_ev = 4'b0001;
    sbq.push_back('{32'd1, "R10 read with same-cycle event"});
    @(negedge clk);
    reg_rd = 1'b0; rx_ev = '0;
    rd(4'd12, 32'd1, "R10 event survives clear");
    wr(4'd0, 32'h0);

    // R8 clear all with same-cycle event
    @(negedge clk);
    reg_addr = 4'd0; reg_wdata = 32'h1; reg_wr = 1'b1; rx_ev = 4'b0001;
    @(negedge clk);
    reg_wr = 1'b0; rx_ev = '0;
    rd(4'd12, 32'd0, "R8 rx frame cleared, event dropped");
    rd(4'd8,  32'd0, "R8 tx frame cleared");
    rd(4'd11, 32'd0, "R8 octets cleared");
    rd(4'd0,  32'd0, "R8 clear bit reads zero");

    // R5/R7 half-scale crossing
    oct_burst(32768);
    check({31'd0, tx_irq}, 32'd0, "R5 no irq just below half");
    oct_burst(1);
    check({31'd0, tx_irq}, 32'd1, "R5 irq at half crossing");
    check({31'd0, rx_irq}, 32'd0, "R7 rx irq stays low");
    rd(4'd11, 32'h8000_7FFF, "R3 octets past half");
    wr(4'd4, 32'h8);
    check({31'd0, tx_irq}, 32'd0, "R7 masked bit gives no irq");
    wr(4'd4, 32'h0);
    check({31'd0, tx_irq}, 32'd1, "R7 unmasked bit gives irq");
    rd(4'd3, 32'h8, "R5 tx status octet bit");
    check({31'd0, tx_irq}, 32'd0, "R6 read clears irq");
    rd(4'd3, 32'h0, "R6 status cleared by read");

    // R5 wrap to zero
    oct_burst(32768);
    check({31'd0, tx_irq}, 32'd0, "R5 no irq at full scale");
    rd(4'd11, 32'hFFFF_FFFF, "R3 octets at full scale");
    oct_burst(1);
    check({31'd0, tx_irq}, 32'd1, "R5 irq on wrap");
    rd(4'd11, 32'd65534, "R5 octets after wrap");
    rd(4'd3, 32'h8, "R5 wrap status bit");
    rd(4'd1, 32'h0, "R5 rx status untouched");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule